// File: doc/BRIEF.md
# Adaptive Binary Arithmetic Coding Core

This block is one coding core for a single type of context in a multi-core arithmetic coder. Each request carries a type field, a context index and a binary symbol. The core accepts a request only when the type field matches its own tag. For an accepted request it narrows a 16-bit coding interval. The interval is held in two bound registers, `low` and `high`, and is scaled using the adaptive symbol counts of the selected context. The core then updates those counts.

A three-state sequencer (idle, calculate, update) spreads each symbol over two busy cycles. The first busy cycle computes and registers the new bounds. The second busy cycle writes back the adapted counts and strobes the bounds out to a downstream renormalization stage. That stage returns its rescaled bounds through a load port while the core is idle.

Each of the four contexts keeps its counts in separate registers. Count adaptation, including the halving that keeps totals bounded, therefore takes one cycle.

Top module: `ac_ctx_core`

## Requirements
- R1: After reset, `out_low` reads 0x0000 and `out_high` reads 0xFFFF, and `busy` and `out_valid` are both low. Every context starts with a symbol-0 count of 1 and a total of 2.
- R2: A request (`in_valid` high while idle) is accepted only when `in_type` equals the `TYPE_TAG` parameter (default 1). Any other type leaves `busy` low, produces no `out_valid`, and changes neither the bounds nor any counts.
- R3: For an accepted symbol, range = high − low + 1. Let f0 be the context's symbol-0 count and T its total. Symbol 0 uses the cumulative pair (0, f0) and symbol 1 uses (f0, T). The new low is low + ⌊range·lo/T⌋ and the new high is low + ⌊range·hi/T⌋ − 1.
- R4: After a symbol is coded, the total of its context rises by 1. The symbol-0 count rises by 1 only when the coded symbol was 0.
- R5: When a context's total would exceed `MAX_TOTAL` (default 8192) after the increment, both symbol frequencies are first halved with rounding up, and the total is rebuilt as their sum. The R4 increment is then applied.
- R6: Let the request be accepted at clock edge k. `busy` is high after edges k and k+1, and `out_valid` is high only for the cycle after edge k+1, at which point the new bounds are on `out_low`/`out_high`. The core is idle again after edge k+2.
- R7: A request presented while `busy` is high is ignored.
- R8: `rn_load` while idle replaces the bounds with `rn_low`/`rn_high` at the next edge. `rn_load` while busy is ignored.
- R9: Whenever the interval range is at least the context total, the newly computed high is not below the newly computed low.
- R10: Each context index selects its own count set. Coding in one context does not alter the counts of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Symbol request strobe |
| in_type | input | 2 | Context type field of the request |
| in_ctx | input | 2 | Context index within the type |
| in_bit | input | 1 | Binary symbol to code |
| rn_load | input | 1 | Load rescaled bounds from renormalization |
| rn_low | input | 16 | Rescaled low bound |
| rn_high | input | 16 | Rescaled high bound |
| busy | output | 1 | Core is sequencing a symbol |
| out_valid | output | 1 | New bounds are presented this cycle |
| out_low | output | 16 | Current low bound |
| out_high | output | 16 | Current high bound |

## Verification
The assertions check properties that hold on every cycle. These are the ordering of the new bounds whenever the range covers the total, the shape of the busy/valid sequence after an accept, the rejection of foreign types, the immunity of the bounds to loads during the update cycle, and the invariants on every count set (symbol-0 count between 1 and the total, total capped). Only the bench scenarios can show that the bound values follow the scaling formula and that counts adapt and halve exactly as required. The bench reaches halving through a long run on one context, with renormalized bounds fed back by a model.

// File: rtl/ac_core_pkg.sv
package ac_core_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CALC   = 2'd1,
    ST_UPDATE = 2'd2
  } ac_state_e;

  // floor(rng * cum / tot) with a wide intermediate product
  function automatic logic [31:0] fn_scale(input logic [31:0] rng,
                                           input logic [31:0] cum,
                                           input logic [31:0] tot);
    logic [63:0] prod;
    prod = {32'd0, rng} * {32'd0, cum};
    if (tot == 32'd0) return 32'd0;
    return 32'(prod / {32'd0, tot});
  endfunction

  // halve a frequency, rounding up (stays at least 1 when input is at least 1)
  function automatic logic [31:0] fn_half_up(input logic [31:0] x);
    return (x + 32'd1) >> 1;
  endfunction

  // cumulative count below the coded symbol
  function automatic logic [31:0] fn_cum_lo(input logic sym, input logic [31:0] f0);
    return sym ? f0 : 32'd0;
  endfunction

  // cumulative count up to and including the coded symbol
  function automatic logic [31:0] fn_cum_hi(input logic sym, input logic [31:0] f0,
                                            input logic [31:0] tot);
    return sym ? tot : f0;
  endfunction

endpackage

// File: rtl/ac_seq_ctrl.sv
module ac_seq_ctrl
  import ac_core_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  output ac_state_e state,
  output logic      accept,
  output logic      calc_en,
  output logic      upd_en
);

  ac_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:   if (req) state_nxt = ST_CALC;
      ST_CALC:   state_nxt = ST_UPDATE;
      ST_UPDATE: state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  assign accept  = (state == ST_IDLE) && req;
  assign calc_en = (state == ST_CALC);
  assign upd_en  = (state == ST_UPDATE);

  // R6: calculate always follows an accept, update always follows calculate
  a_r6_calc_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> calc_en);
  a_r6_update_after_calc: assert property (@(posedge clk) disable iff (!rst_n)
    calc_en |=> upd_en);

endmodule

// File: rtl/ac_ctx_counts.sv
module ac_ctx_counts
  import ac_core_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int MAX_TOTAL = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             sym,
  output logic [CNT_W-1:0] f0,
  output logic [CNT_W-1:0] tot
);

  logic [31:0] f1_w;
  logic [31:0] f0_h;
  logic [31:0] f1_h;
  logic        over;
  logic [31:0] f0_n;
  logic [31:0] tot_n;

  assign f1_w = 32'(tot) - 32'(f0);
  assign over = (32'(tot) + 32'd1) > 32'(MAX_TOTAL);

  always_comb begin
    if (over) begin
      f0_h = fn_half_up(32'(f0));
      f1_h = fn_half_up(f1_w);
    end else begin
      f0_h = 32'(f0);
      f1_h = f1_w;
    end
    f0_n  = f0_h + (sym ? 32'd0 : 32'd1);
    tot_n = f0_h + f1_h + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f0  <= CNT_W'(1);
      tot <= CNT_W'(2);
    end else if (upd) begin
      f0  <= CNT_W'(f0_n);
      tot <= CNT_W'(tot_n);
    end
  end

  // R4: both symbol frequencies stay at least 1
  a_r4_freq_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (f0 >= CNT_W'(1)) && (f0 < tot));
  // R5: the total never passes the cap
  a_r5_total_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tot) <= 32'(MAX_TOTAL));
  // R4: without halving, the total grows by exactly one per coded symbol
  a_r4_total_step: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !over) |=> (32'(tot) == 32'($past(tot)) + 32'd1));

endmodule

// File: rtl/ac_interval.sv
module ac_interval
  import ac_core_pkg::*;
#(
  parameter int CW    = 16,
  parameter int CNT_W = 14,
  localparam int RW   = CW + 1
) (
  input  logic [CW-1:0]    low,
  input  logic [CW-1:0]    high,
  input  logic             sym,
  input  logic [CNT_W-1:0] f0,
  input  logic [CNT_W-1:0] tot,
  output logic [RW-1:0]    rng,
  output logic [CW-1:0]    nlow,
  output logic [CW-1:0]    nhigh
);

  logic [31:0] c_lo;
  logic [31:0] c_hi;
  logic [31:0] sum_lo;
  logic [31:0] sum_hi;

  assign rng    = RW'(high) - RW'(low) + RW'(1);
  assign c_lo   = fn_cum_lo(sym, 32'(f0));
  assign c_hi   = fn_cum_hi(sym, 32'(f0), 32'(tot));
  assign sum_lo = 32'(low) + fn_scale(32'(rng), c_lo, 32'(tot));
  assign sum_hi = 32'(low) + fn_scale(32'(rng), c_hi, 32'(tot)) - 32'd1;
  assign nlow   = CW'(sum_lo);
  assign nhigh  = CW'(sum_hi);

endmodule

// File: rtl/ac_ctx_core.sv
module ac_ctx_core
  import ac_core_pkg::*;
#(
  parameter int TYPE_W                = 2,
  parameter int CTX_W                 = 2,
  parameter logic [TYPE_W-1:0] TYPE_TAG = 1,
  parameter int CW                    = 16,
  parameter int CNT_W                 = 14,
  parameter int MAX_TOTAL             = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [TYPE_W-1:0] in_type,
  input  logic [CTX_W-1:0]  in_ctx,
  input  logic              in_bit,
  input  logic              rn_load,
  input  logic [CW-1:0]     rn_low,
  input  logic [CW-1:0]     rn_high,
  output logic              busy,
  output logic              out_valid,
  output logic [CW-1:0]     out_low,
  output logic [CW-1:0]     out_high
);

  localparam int NUM_CTX = 1 << CTX_W;
  localparam int RW      = CW + 1;

  ac_state_e        state;
  logic             tag_match;
  logic             req;
  logic             accept;
  logic             calc_en;
  logic             upd_en;
  logic [CTX_W-1:0] ctx_l;
  logic             bit_l;
  logic [CNT_W-1:0] f0_l;
  logic [CNT_W-1:0] tot_l;
  logic [CW-1:0]    low_q;
  logic [CW-1:0]    high_q;
  logic [RW-1:0]    rng;
  logic [CW-1:0]    nlow;
  logic [CW-1:0]    nhigh;
  logic [CNT_W-1:0] f0_arr  [NUM_CTX];
  logic [CNT_W-1:0] tot_arr [NUM_CTX];

  assign tag_match = (in_type == TYPE_TAG);
  assign req       = in_valid && tag_match;

  ac_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .state   (state),
    .accept  (accept),
    .calc_en (calc_en),
    .upd_en  (upd_en)
  );

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    ac_ctx_counts #(
      .CNT_W     (CNT_W),
      .MAX_TOTAL (MAX_TOTAL)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (upd_en && (ctx_l == CTX_W'(g))),
      .sym   (bit_l),
      .f0    (f0_arr[g]),
      .tot   (tot_arr[g])
    );
  end

  // lookup: capture the request and the selected context's counts
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_l <= '0;
      bit_l <= 1'b0;
      f0_l  <= CNT_W'(1);
      tot_l <= CNT_W'(2);
    end else if (accept) begin
      ctx_l <= in_ctx;
      bit_l <= in_bit;
      f0_l  <= f0_arr[in_ctx];
      tot_l <= tot_arr[in_ctx];
    end
  end

  ac_interval #(
    .CW    (CW),
    .CNT_W (CNT_W)
  ) u_intv (
    .low   (low_q),
    .high  (high_q),
    .sym   (bit_l),
    .f0    (f0_l),
    .tot   (tot_l),
    .rng   (rng),
    .nlow  (nlow),
    .nhigh (nhigh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '1;
    end else if (calc_en) begin
      low_q  <= nlow;
      high_q <= nhigh;
    end else if ((state == ST_IDLE) && rn_load) begin
      low_q  <= rn_low;
      high_q <= rn_high;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign out_valid = upd_en;
  assign out_low   = low_q;
  assign out_high  = high_q;

  // R9: a range that covers the total always yields an ordered interval
  a_r9_bound_order: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en && (32'(rng) >= 32'(tot_l))) |-> (nhigh >= nlow));
  // R3: the new low never moves below the old low
  a_r3_low_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    calc_en |-> (nlow >= low_q));
  // R6: busy without valid right after accept, valid one cycle later, single pulse
  a_r6_busy_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !out_valid));
  a_r6_valid_second: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 out_valid);
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R2: a foreign type presented while idle does not start a sequence
  a_r2_reject_type: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && in_valid && !tag_match) |=> !busy);
  // R8: a load during the update cycle leaves the bounds alone
  a_r8_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && rn_load) |=> ($stable(out_low) && $stable(out_high)));

endmodule

// File: tb/ac_ctx_core_bench.sv
`timescale 1ns/1ps
module ac_ctx_core_bench;

  localparam int MAXT = 8192;
  localparam logic [1:0] TAG = 2'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_type = 2'd0;
  logic [1:0]  in_ctx = 2'd0;
  logic        in_bit = 1'b0;
  logic        rn_load = 1'b0;
  logic [15:0] rn_low = 16'd0;
  logic [15:0] rn_high = 16'd0;
  logic        busy;
  logic        out_valid;
  logic [15:0] out_low;
  logic [15:0] out_high;

  always #2.5 clk = ~clk;

  ac_ctx_core u_ac_ctx_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_type   (in_type),
    .in_ctx    (in_ctx),
    .in_bit    (in_bit),
    .rn_load   (rn_load),
    .rn_low    (rn_low),
    .rn_high   (rn_high),
    .busy      (busy),
    .out_valid (out_valid),
    .out_low   (out_low),
    .out_high  (out_high)
  );

  int  n_total = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  int  halvings = 0;

  longint m_low;
  longint m_high;
  longint m_f0  [4];
  longint m_tot [4];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_adapt(input int c, input bit b);
    longint f1;
    f1 = m_tot[c] - m_f0[c];
    if (m_tot[c] + 1 > MAXT) begin
      m_f0[c] = (m_f0[c] + 1) / 2;
      f1 = (f1 + 1) / 2;
      halvings++;
    end
    m_tot[c] = m_f0[c] + f1 + 1;
    if (!b) m_f0[c] = m_f0[c] + 1;
  endtask

  task automatic model_renorm();
    bit go;
    go = 1'b1;
    while (go) begin
      if (m_high < 32768) begin
        m_low = 2 * m_low; m_high = 2 * m_high + 1;
      end else if (m_low >= 32768) begin
        m_low = 2 * (m_low - 32768); m_high = 2 * (m_high - 32768) + 1;
      end else if (m_low >= 16384 && m_high < 49152) begin
        m_low = 2 * (m_low - 16384); m_high = 2 * (m_high - 16384) + 1;
      end else begin
        go = 1'b0;
      end
    end
  endtask

  // code one symbol; stress holds the request and a junk load through the busy cycles
  task automatic code_sym(input int c, input bit b, input bit stress, input string req);
    longint rng, clo, chi, el, eh;
    rng = m_high - m_low + 1;
    clo = b ? m_f0[c] : 0;
    chi = b ? m_tot[c] : m_f0[c];
    el  = m_low + (rng * clo) / m_tot[c];
    eh  = m_low + (rng * chi) / m_tot[c] - 1;
    @(negedge clk);
    in_valid = 1'b1; in_type = TAG; in_ctx = 2'(c); in_bit = b;
    @(posedge clk);
    @(negedge clk);
    if (stress) begin
      in_bit = ~b; rn_load = 1'b1; rn_low = 16'h1234; rn_high = 16'h5678;
    end else begin
      in_valid = 1'b0;
    end
    chk(busy && !out_valid, "R6 busy-first", {busy, out_valid}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 valid", out_valid, 1);
    chk(out_low == 16'(el), {req, " low"}, out_low, el);
    chk(out_high == 16'(eh), {req, " high"}, out_high, eh);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    m_low = el; m_high = eh;
    model_adapt(c, b);
    if (stress) begin
      chk(!busy && !out_valid, "R7 idle after busy", {busy, out_valid}, 0);
      chk(out_low == 16'(el) && out_high == 16'(eh), "R8 load ignored while busy",
          {out_low, out_high}, {16'(el), 16'(eh)});
    end else begin
      chk(!busy, "R6 idle", busy, 0);
    end
    model_renorm();
    rn_load = 1'b1; rn_low = 16'(m_low); rn_high = 16'(m_high);
    @(posedge clk);
    @(negedge clk);
    rn_load = 1'b0;
    chk(out_low == 16'(m_low) && out_high == 16'(m_high), "R8 load idle",
        {out_low, out_high}, {16'(m_low), 16'(m_high)});
  endtask

  initial begin
    #(200000.0 * 5.0);
    if (!done) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    m_low = 0; m_high = 65535;
    for (int i = 0; i < 4; i++) begin
      m_f0[i] = 1; m_tot[i] = 2;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_low == 16'h0000, "R1 low", out_low, 0);
    chk(out_high == 16'hFFFF, "R1 high", out_high, 65535);
    chk(!busy && !out_valid, "R1 idle", {busy, out_valid}, 0);

    // R2 foreign types are ignored
    for (int t = 0; t < 4; t++) begin
      if (2'(t) != TAG) begin
        in_valid = 1'b1; in_type = 2'(t); in_ctx = 2'(t); in_bit = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(!busy && !out_valid, "R2 reject busy", {busy, out_valid}, 0);
        @(posedge clk);
        @(negedge clk);
        chk(!out_valid && out_low == 16'h0000 && out_high == 16'hFFFF,
            "R2 reject bounds", {out_low, out_high}, 32'h0000FFFF);
      end
    end

    // R3 R4: first symbols from reset counts; R2 rejected requests changed no counts
    code_sym(0, 1'b0, 1'b0, "R3 R4 first sym0");
    code_sym(0, 1'b0, 1'b0, "R4 second sym0");
    code_sym(1, 1'b1, 1'b0, "R3 R10 ctx1 sym1");

    // sweep: R10 interleaved contexts, R7 R8 stress rounds
    for (int r = 0; r < 10; r++) begin
      for (int c = 0; c < 4; c++) begin
        code_sym(c, bit'(((r * 3 + c) % 5) < 2), bit'(r == 3 || r == 7), "R3 R10 sweep");
      end
    end

    // R5: long run on one context drives its total through the cap
    for (int i = 0; i < 8400; i++) begin
      code_sym(3, bit'((i % 4) != 0), 1'b0, "R5 R3 long run");
    end
    chk(halvings > 0, "R5 halving reached", halvings, 1);

    // R10: other contexts still use their own counts
    for (int c = 0; c < 3; c++) begin
      code_sym(c, 1'b0, 1'b0, "R10 after long run");
      code_sym(c, 1'b1, 1'b0, "R10 after long run");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule